// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central hazard controller for a pipeline that lets instructions run out of order. Five execution units are served: two multipliers, one adder, one divider and one integer unit. One decoded instruction per cycle is offered to it as an operation class, a destination register and two source registers. The controller issues instructions in program order. It tells each unit when its source operands may be read from the register file. It tells each unit when its finished result may be written back. Each unit reports the end of its execution on a done line.

The controller holds one status record per unit and one result-status entry per architectural register. A unit record holds the stage, the destination and the two sources, the unit that will produce each source, and a ready-but-unread flag for each source. A result-status entry names the unit that will write that register, or is blank when no unit will. Structural and write-after-write hazards stall issue. Read-after-write hazards hold back the operand read. Write-after-read hazards hold back the result write. The block does no register renaming and no forwarding. An operand produced by a result write can be read no earlier than the next cycle.

Top module: `sb_issue_ctrl`

## Requirements
- R1: The operation class selects the unit, with encodings 0 integer, 1 add, 2 multiply and 3 divide. Bits of `issueGrant`, `readGo`, `writeGo` and `execDone` are unit 0 first multiplier, 1 second multiplier, 2 adder, 3 divider and 4 integer unit. A multiply takes unit 0 when unit 0 is free and unit 1 otherwise. On acceptance `issueGrant` is one-hot on the chosen unit.
- R2: An instruction whose unit is busy is not accepted. `instAccept` and `issueGrant` stay low. A unit is busy from the edge that issues into it until the edge that ends its `writeGo` cycle.
- R3: An instruction whose destination is the destination of any busy unit is not accepted, even when its unit is free. It is accepted in the first cycle after that writer's `writeGo` cycle.
- R4: With no busy unit due to write either source, `readGo` for the issued unit is high exactly once, in the cycle right after the issue cycle.
- R5: While a source is due to be written by a busy unit, the consumer gets no `readGo`. Its `readGo` comes in the cycle after the producer's `writeGo` cycle, never in the same cycle.
- R6: `execDone` has effect only for a unit that has read its operands and not yet reported done. At any other time it is ignored and causes no `writeGo`.
- R7: After a unit that has read its operands reports `execDone`, `writeGo` is high in the next cycle unless R8 holds it back. The unit accepts a new instruction in the cycle after `writeGo`.
- R8: A finished unit gets no `writeGo` while an earlier issued instruction has a source equal to its destination, that source is ready, and the operands are still unread. `writeGo` follows in the cycle after that instruction's `readGo`.
- R9: Every unit that qualifies in a cycle gets its `readGo` or `writeGo` in that cycle, so several bits may be high together.
- R10: After reset all units are free, all result-status entries are blank, and `readGo` and `writeGo` are low.
- R11: A later independent instruction reads its operands while an earlier issued instruction is still waiting for a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | A decoded instruction is offered this cycle |
| instClass | input | 2 | Operation class (0 int, 1 add, 2 mul, 3 div) |
| instDst | input | $clog2(NUM_REGS) | Destination register |
| instSrc1 | input | $clog2(NUM_REGS) | First source register |
| instSrc2 | input | $clog2(NUM_REGS) | Second source register |
| execDone | input | 5 | Per-unit end-of-execution pulse |
| instAccept | output | 1 | Offered instruction is issued at this edge |
| issueGrant | output | 5 | One-hot unit receiving the issued instruction |
| readGo | output | 5 | Per-unit permission to read operands this cycle |
| writeGo | output | 5 | Per-unit permission to write the result this cycle |

## Verification
The assertions assume that a unit raises `execDone` only for work it is executing, that the offered instruction is held stable through its cycle, and that the class code is always defined. The bench pulses `execDone` at chosen cycles. Some of these pulses deliberately fall outside the execute step, to exercise R6. All other stimulus keeps within those limits. Each instruction is offered for a single cycle and re-offered explicitly after a stall. This keeps the in-order issue rule visible at the ports.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU = 5;
  localparam int FU_W   = $clog2(NUM_FU);

  localparam int FU_MUL0 = 0;
  localparam int FU_MUL1 = 1;
  localparam int FU_ADD  = 2;
  localparam int FU_DIV  = 3;
  localparam int FU_INT  = 4;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_ADD = 2'd1,
    CLS_MUL = 2'd2,
    CLS_DIV = 2'd3
  } opclass_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_RD = 2'd1,
    ST_EXEC    = 2'd2,
    ST_WAIT_WR = 2'd3
  } stage_e;

  typedef struct packed {
    logic              issue;
    logic [NUM_FU-1:0] issueSel;
    logic [NUM_FU-1:0] readSel;
    logic [NUM_FU-1:0] writeSel;
  } strobe_t;
endpackage

// File: rtl/sb_status_table.sv
module sb_status_table
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [REG_W-1:0]              instDst,
  input  logic [REG_W-1:0]              instSrc1,
  input  logic [REG_W-1:0]              instSrc2,
  input  logic [NUM_FU-1:0]             execDone,
  input  strobe_t                       stb,
  output stage_e [NUM_FU-1:0]           stageQ,
  output logic [NUM_FU-1:0][REG_W-1:0]  fiQ,
  output logic [NUM_FU-1:0][REG_W-1:0]  fjQ,
  output logic [NUM_FU-1:0][REG_W-1:0]  fkQ,
  output logic [NUM_FU-1:0]             rjQ,
  output logic [NUM_FU-1:0]             rkQ,
  output logic                          dstPending
);
  logic [NUM_REGS-1:0]            regBusy;
  logic [NUM_REGS-1:0][FU_W-1:0]  regOwner;
  logic [NUM_FU-1:0]              qjV, qkV;
  logic [NUM_FU-1:0][FU_W-1:0]    qjQ, qkQ;
  logic [FU_W-1:0]                grantIdx;
  logic                           src1Wait, src2Wait;

  always_comb begin
    grantIdx = '0;
    for (int u = 0; u < NUM_FU; u++)
      if (stb.issueSel[u]) grantIdx = FU_W'(u);
  end

  // A producer writing back in the issue cycle counts as already done.
  assign src1Wait   = regBusy[instSrc1] && !stb.writeSel[regOwner[instSrc1]];
  assign src2Wait   = regBusy[instSrc2] && !stb.writeSel[regOwner[instSrc2]];
  assign dstPending = regBusy[instDst];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int u = 0; u < NUM_FU; u++) begin
        stageQ[u] <= ST_IDLE;
        fiQ[u] <= '0;
        fjQ[u] <= '0;
        fkQ[u] <= '0;
        qjQ[u] <= '0;
        qkQ[u] <= '0;
      end
      rjQ <= '0;
      rkQ <= '0;
      qjV <= '0;
      qkV <= '0;
      regBusy <= '0;
      for (int r = 0; r < NUM_REGS; r++) regOwner[r] <= '0;
    end else begin
      for (int u = 0; u < NUM_FU; u++) begin
        if (stb.issueSel[u]) begin
          stageQ[u] <= ST_WAIT_RD;
          fiQ[u] <= instDst;
          fjQ[u] <= instSrc1;
          fkQ[u] <= instSrc2;
          qjQ[u] <= regOwner[instSrc1];
          qkQ[u] <= regOwner[instSrc2];
          qjV[u] <= src1Wait;
          qkV[u] <= src2Wait;
          rjQ[u] <= !src1Wait;
          rkQ[u] <= !src2Wait;
        end else begin
          unique case (stageQ[u])
            ST_WAIT_RD: begin
              if (stb.readSel[u]) begin
                stageQ[u] <= ST_EXEC;
                rjQ[u] <= 1'b0;
                rkQ[u] <= 1'b0;
              end else begin
                if (qjV[u] && stb.writeSel[qjQ[u]]) begin
                  rjQ[u] <= 1'b1;
                  qjV[u] <= 1'b0;
                end
                if (qkV[u] && stb.writeSel[qkQ[u]]) begin
                  rkQ[u] <= 1'b1;
                  qkV[u] <= 1'b0;
                end
              end
            end
            ST_EXEC:    if (execDone[u]) stageQ[u] <= ST_WAIT_WR;
            ST_WAIT_WR: if (stb.writeSel[u]) stageQ[u] <= ST_IDLE;
            default:    ;
          endcase
        end
      end
      for (int w = 0; w < NUM_FU; w++)
        if (stb.writeSel[w]) regBusy[fiQ[w]] <= 1'b0;
      if (stb.issue) begin
        regBusy[instDst]  <= 1'b1;
        regOwner[instDst] <= grantIdx;
      end
    end
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
    assert_issue_free_R2: assert property (@(posedge clk) disable iff (!rstN)
      stb.issueSel[u] |-> stageQ[u] == ST_IDLE);
    assert_dst_owned_R3: assert property (@(posedge clk) disable iff (!rstN)
      stageQ[u] != ST_IDLE |-> regBusy[fiQ[u]] && regOwner[fiQ[u]] == FU_W'(u));
    assert_read_enters_exec_R4: assert property (@(posedge clk) disable iff (!rstN)
      stb.readSel[u] |=> stageQ[u] == ST_EXEC);
    assert_read_no_producer_R5: assert property (@(posedge clk) disable iff (!rstN)
      stb.readSel[u] |-> !qjV[u] && !qkV[u]);
    assert_write_frees_R7: assert property (@(posedge clk) disable iff (!rstN)
      stb.writeSel[u] |=> stageQ[u] == ST_IDLE);
  end
endmodule

// File: rtl/sb_issue_logic.sv
module sb_issue_logic
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          instValid,
  input  logic [1:0]                    instClass,
  input  logic                          dstPending,
  input  stage_e [NUM_FU-1:0]           stageQ,
  input  logic [NUM_FU-1:0][REG_W-1:0]  fiQ,
  input  logic [NUM_FU-1:0][REG_W-1:0]  fjQ,
  input  logic [NUM_FU-1:0][REG_W-1:0]  fkQ,
  input  logic [NUM_FU-1:0]             rjQ,
  input  logic [NUM_FU-1:0]             rkQ,
  output strobe_t                       stb
);
  int unsigned       target;
  logic [NUM_FU-1:0] warBlock;

  always_comb begin
    unique case (opclass_e'(instClass))
      CLS_INT: target = FU_INT;
      CLS_ADD: target = FU_ADD;
      CLS_DIV: target = FU_DIV;
      default: target = (stageQ[FU_MUL0] == ST_IDLE) ? FU_MUL0 : FU_MUL1;
    endcase
  end

  always_comb begin
    warBlock = '0;
    for (int u = 0; u < NUM_FU; u++)
      for (int v = 0; v < NUM_FU; v++)
        if (v != u && stageQ[v] == ST_WAIT_RD &&
            ((rjQ[v] && fjQ[v] == fiQ[u]) || (rkQ[v] && fkQ[v] == fiQ[u])))
          warBlock[u] = 1'b1;
  end

  always_comb begin
    stb.issue    = instValid && stageQ[target] == ST_IDLE && !dstPending;
    stb.issueSel = '0;
    if (stb.issue) stb.issueSel[target] = 1'b1;
    for (int u = 0; u < NUM_FU; u++) begin
      stb.readSel[u]  = stageQ[u] == ST_WAIT_RD && rjQ[u] && rkQ[u];
      stb.writeSel[u] = stageQ[u] == ST_WAIT_WR && !warBlock[u];
    end
  end

  assert_grant_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.issueSel));
  assert_grant_has_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueSel != '0 |-> instValid);
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [1:0]        instClass,
  input  logic [REG_W-1:0]  instDst,
  input  logic [REG_W-1:0]  instSrc1,
  input  logic [REG_W-1:0]  instSrc2,
  input  logic [NUM_FU-1:0] execDone,
  output logic              instAccept,
  output logic [NUM_FU-1:0] issueGrant,
  output logic [NUM_FU-1:0] readGo,
  output logic [NUM_FU-1:0] writeGo
);
  strobe_t                      stb;
  stage_e [NUM_FU-1:0]          stageQ;
  logic [NUM_FU-1:0][REG_W-1:0] fiQ, fjQ, fkQ;
  logic [NUM_FU-1:0]            rjQ, rkQ;
  logic                         dstPending;

  sb_issue_logic #(.NUM_REGS(NUM_REGS)) ctrl_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .dstPending(dstPending), .stageQ(stageQ), .fiQ(fiQ), .fjQ(fjQ),
    .fkQ(fkQ), .rjQ(rjQ), .rkQ(rkQ), .stb(stb)
  );

  sb_status_table #(.NUM_REGS(NUM_REGS)) table_i (
    .clk(clk), .rstN(rstN), .instDst(instDst), .instSrc1(instSrc1),
    .instSrc2(instSrc2), .execDone(execDone), .stb(stb), .stageQ(stageQ),
    .fiQ(fiQ), .fjQ(fjQ), .fkQ(fkQ), .rjQ(rjQ), .rkQ(rkQ),
    .dstPending(dstPending)
  );

  assign instAccept = stb.issue;
  assign issueGrant = stb.issueSel;
  assign readGo     = stb.readSel;
  assign writeGo    = stb.writeSel;
endmodule

// File: tb/sb_issue_ctrl_tb_top.sv
module sb_issue_ctrl_tb_top;
  localparam logic [4:0] M0 = 5'b00001, M1 = 5'b00010, AD = 5'b00100,
                         DV = 5'b01000, IN = 5'b10000;
  localparam logic [1:0] C_INT = 2'd0, C_ADD = 2'd1, C_MUL = 2'd2, C_DIV = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [1:0] instClass = '0;
  logic [4:0] instDst = '0, instSrc1 = '0, instSrc2 = '0;
  logic [4:0] execDone = '0;
  logic instAccept;
  logic [4:0] issueGrant, readGo, writeGo;

  always #5 clk = ~clk;

  sb_issue_ctrl dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .instDst(instDst), .instSrc1(instSrc1), .instSrc2(instSrc2),
    .execDone(execDone), .instAccept(instAccept), .issueGrant(issueGrant),
    .readGo(readGo), .writeGo(writeGo)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;
  string curTag = "R10";

  typedef struct {
    int cyc;
    logic [4:0] rd;
    logic [4:0] wr;
    string tag;
  } exp_t;
  exp_t expQ[$];

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  task automatic expectEv(int c, logic [4:0] r, logic [4:0] w, string tag);
    exp_t e;
    e.cyc = c; e.rd = r; e.wr = w; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: every readGo/writeGo event must match a queued expectation
  always @(negedge clk) begin
    bit hit;
    hit = 1'b0;
    if (rstN && (readGo != 0 || writeGo != 0)) begin
      for (int i = 0; i < expQ.size(); i++) begin
        if (!hit && expQ[i].cyc == cyc) begin
          chk(readGo == expQ[i].rd, expQ[i].tag, "readGo", readGo, expQ[i].rd);
          chk(writeGo == expQ[i].wr, expQ[i].tag, "writeGo", writeGo, expQ[i].wr);
          expQ.delete(i);
          hit = 1'b1;
        end
      end
      if (!hit) chk(1'b0, curTag, "unexpected rd/wr event", {readGo, writeGo}, 0);
    end
  end

  task automatic toCycle(int c);
    @(negedge clk);
    while (cyc < c) @(negedge clk);
    if (cyc != c) chk(1'b0, curTag, "schedule slip", cyc, c);
  endtask

  task automatic issueAt(int c, logic [1:0] cls, logic [4:0] d, logic [4:0] s1,
                         logic [4:0] s2, bit expAcc, logic [4:0] expGrant, string tag);
    toCycle(c);
    instValid = 1'b1; instClass = cls; instDst = d; instSrc1 = s1; instSrc2 = s2;
    #1;
    chk(instAccept == expAcc, tag, "instAccept", instAccept, expAcc);
    chk(issueGrant == (expAcc ? expGrant : 5'b0), tag, "issueGrant", issueGrant,
        expAcc ? expGrant : 5'b0);
    @(posedge clk);
    #1 instValid = 1'b0;
  endtask

  task automatic doneAt(int c, logic [4:0] mask);
    toCycle(c);
    execDone = mask;
    @(posedge clk);
    #1 execDone = '0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired in scenario %s", curTag);
      summary();
    end
  end

  initial begin
    int b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(readGo == 0, "R10", "readGo after reset", readGo, 0);
    chk(writeGo == 0, "R10", "writeGo after reset", writeGo, 0);
    chk(instAccept == 0, "R10", "instAccept idle", instAccept, 0);

    // A: basic flow, busy unit, reuse after write (R1 R2 R4 R7)
    curTag = "R7"; b = cyc + 3;
    expectEv(b + 1, IN, 0, "R4");
    expectEv(b + 3, 0, IN, "R7");
    expectEv(b + 5, IN, 0, "R7");
    expectEv(b + 7, 0, IN, "R7");
    issueAt(b, C_INT, 1, 2, 3, 1, IN, "R1");
    doneAt(b + 2, IN);
    issueAt(b + 3, C_INT, 4, 5, 6, 0, 0, "R2");
    issueAt(b + 4, C_INT, 4, 5, 6, 1, IN, "R7");
    doneAt(b + 6, IN);

    // B: multiplier allocation, all units, joint writes (R1 R2 R9)
    curTag = "R1"; b = b + 10;
    expectEv(b + 1, M0, 0, "R1");
    expectEv(b + 2, M1, 0, "R1");
    expectEv(b + 4, 0, M0 | M1, "R9");
    expectEv(b + 6, AD, 0, "R1");
    expectEv(b + 7, DV, 0, "R1");
    expectEv(b + 9, 0, AD | DV, "R9");
    issueAt(b, C_MUL, 10, 1, 2, 1, M0, "R1");
    issueAt(b + 1, C_MUL, 11, 3, 4, 1, M1, "R1");
    issueAt(b + 2, C_MUL, 12, 5, 6, 0, 0, "R2");
    doneAt(b + 3, M0 | M1);
    issueAt(b + 5, C_ADD, 13, 14, 15, 1, AD, "R1");
    issueAt(b + 6, C_DIV, 16, 17, 18, 1, DV, "R1");
    doneAt(b + 8, AD | DV);

    // C: RAW wait, out-of-order read, WAW stall (R3 R5 R11)
    curTag = "R5"; b = b + 12;
    expectEv(b + 1, DV, 0, "R4");
    expectEv(b + 3, M0, 0, "R11");
    expectEv(b + 5, 0, DV | M0, "R7");
    expectEv(b + 6, AD, 0, "R5");
    expectEv(b + 7, IN, 0, "R3");
    expectEv(b + 9, 0, AD | IN, "R9");
    issueAt(b, C_DIV, 20, 1, 2, 1, DV, "R1");
    issueAt(b + 1, C_ADD, 21, 20, 3, 1, AD, "R5");
    issueAt(b + 2, C_MUL, 22, 4, 5, 1, M0, "R11");
    issueAt(b + 3, C_INT, 20, 6, 7, 0, 0, "R3");
    doneAt(b + 4, DV | M0);
    issueAt(b + 6, C_INT, 20, 6, 7, 1, IN, "R3");
    doneAt(b + 8, AD | IN);

    // D: WAR stall on write, joint reads (R8 R9)
    curTag = "R8"; b = b + 12;
    expectEv(b + 1, DV, 0, "R4");
    expectEv(b + 4, IN, 0, "R4");
    expectEv(b + 6, 0, DV, "R8");
    expectEv(b + 7, AD | M0, 0, "R9");
    expectEv(b + 8, 0, IN, "R8");
    expectEv(b + 10, 0, AD | M0, "R9");
    issueAt(b, C_DIV, 1, 2, 3, 1, DV, "R1");
    issueAt(b + 1, C_ADD, 4, 1, 5, 1, AD, "R5");
    issueAt(b + 2, C_MUL, 6, 1, 7, 1, M0, "R5");
    issueAt(b + 3, C_INT, 5, 8, 9, 1, IN, "R8");
    doneAt(b + 5, DV | IN);
    doneAt(b + 9, AD | M0);

    // E: stray execDone pulses are ignored (R6)
    curTag = "R6"; b = b + 13;
    expectEv(b + 2, AD, 0, "R4");
    expectEv(b + 6, 0, AD, "R6");
    doneAt(b, 5'b11111);
    issueAt(b + 1, C_ADD, 2, 30, 31, 1, AD, "R6");
    doneAt(b + 2, AD);
    doneAt(b + 5, AD);

    toCycle(b + 9);
    foreach (expQ[i])
      chk(1'b0, expQ[i].tag, "missing event at cycle", expQ[i].cyc, 1);
    finished = 1'b1;
    summary();
  end
endmodule